// File: doc/BRIEF.md
# Waveform Channel Sequence List

This block holds the ordered list of output channel numbers that make up one frame of a multi-channel waveform. While the configuration phase is active, software pushes channel numbers one at a time; the first number pushed becomes the first channel of every frame, and each later push is appended behind it. A dedicated clear strobe empties the list before a new sequence is loaded.

Once configuration ends, the block turns into a cyclic player. The sample data path raises a next-channel request each time it has routed one sample word. On each request the block moves to the next stored channel, and after the last one it returns to the head of the list. The current channel number is always present on an output, so the data path can steer the sample word in hand to the right converter. A one-cycle pulse marks each return to the head.

Pushes or clears outside configuration, and pushes into a full list, are refused and latch an error indication.

Top module: `chan_seq_list`

## Requirements
- R1: After reset the entry count is 0, the current channel is 0, the wrap pulse is low and the error flag is low.
- R2: While `cfgActive` is high, a `wrStb` cycle appends `wrChan` (4-bit channel number) at the tail and raises the entry count by one. The entry pushed first is the first one presented on `curChan`.
- R3: A `wrStb` or `clrStb` while `cfgActive` is low leaves the list and entry count unchanged and sets the error flag.
- R4: The error flag stays high until a clear is accepted during configuration. Accepted pushes do not lower it.
- R5: The list holds 16 entries. A push into a full list is dropped, the count stays 16, and the error flag is set.
- R6: While `cfgActive` is low and the list is not empty, each `nextReq` cycle advances `curChan` to the next stored entry in push order. After the last entry it returns to entry 0, and `listWrap` is high during exactly the cycle that follows that request.
- R7: While `cfgActive` is high, the read position is held at entry 0 and `nextReq` has no effect, so every generation run starts at the head.
- R8: With an empty list, `curChan` reads 0, and `nextReq` produces no wrap pulse.
- R9: An accepted clear empties the list (count 0). If a push arrives in the same cycle, the clear wins: the push is dropped and does not set the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgActive | input | 1 | High during a configuration phase |
| wrStb | input | 1 | Push strobe for one channel number |
| wrChan | input | 4 | Channel number to push |
| clrStb | input | 1 | Clear strobe for the list |
| nextReq | input | 1 | Data path request to move to the next channel |
| curChan | output | 4 | Channel number at the read position |
| listWrap | output | 1 | One-cycle pulse after a request that returned to the head |
| entryCount | output | 5 | Number of stored entries |
| cfgErr | output | 1 | Sticky flag for refused pushes or clears |

## Verification
Two pairs of events can land in the same cycle. The first is a clear and a push in the same configuration cycle. The bench loads three entries, then raises both strobes together. It expects an empty list with the error flag low, which shows the push was dropped as a loser of the priority and not as a fault. The second is a request that reaches the last entry. Here the step and the return to the head share one edge. The bench sweeps every list length from 1 to 16, and for each length it expects the wrap pulse in exactly the cycles whose position index equals the length minus one. The single-entry list wraps on every request.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;

  // Per-cycle commands from the control to the datapath.
  typedef struct packed {
    logic clear;   // empty list, zero all pointers
    logic push;    // append wrChan at the tail
    logic step;    // advance read position
    logic wrap;    // this step returns to the head
    logic holdRd;  // configuration: pin read position at head
  } seqStrb_t;

endpackage

// File: rtl/chan_seq_ctrl.sv
module chan_seq_ctrl
  import chan_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cfgActive,
  input  logic     wrStb,
  input  logic     clrStb,
  input  logic     nextReq,
  input  logic     isFull,
  input  logic     isEmpty,
  input  logic     atLast,
  output seqStrb_t strb,
  output logic     cfgErr
);

  logic badPush;
  logic badClear;

  always_comb begin
    strb.clear  = cfgActive & clrStb;
    strb.push   = cfgActive & wrStb & ~clrStb & ~isFull;
    strb.step   = ~cfgActive & nextReq & ~isEmpty;
    strb.wrap   = ~cfgActive & nextReq & ~isEmpty & atLast;
    strb.holdRd = cfgActive;
    // A push that loses to a same-cycle clear is not an error.
    badPush  = wrStb & (~cfgActive | (isFull & ~clrStb));
    badClear = clrStb & ~cfgActive;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgErr <= 1'b0;
    end else if (cfgActive && clrStb) begin
      cfgErr <= 1'b0;
    end else if (badPush || badClear) begin
      cfgErr <= 1'b1;
    end
  end

  // Sticky flag only drops on an accepted clear.
  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgErr && !(cfgActive && clrStb)) |=> cfgErr);

  // Any push outside configuration must leave the flag raised.
  assert_err_on_late_push_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && !cfgActive) |=> cfgErr);

endmodule

// File: rtl/chan_seq_dpath.sv
module chan_seq_dpath
  import chan_seq_pkg::*;
#(
  parameter int CHAN_W = 4,
  parameter int DEPTH  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrb_t          strb,
  input  logic [CHAN_W-1:0] wrChan,
  output logic [CHAN_W-1:0] curChan,
  output logic              listWrap,
  output logic [CNT_W-1:0]  entryCount,
  output logic              isFull,
  output logic              isEmpty,
  output logic              atLast
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [CHAN_W-1:0] entry [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [CNT_W-1:0]  count;
  logic              wrapQ;

  // One register per list slot; each loads only when the tail points at it.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entry[i] <= '0;
      end else if (strb.push && (wrPtr == PTR_W'(i))) begin
        entry[i] <= wrChan;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      count <= '0;
    end else if (strb.clear) begin
      wrPtr <= '0;
      count <= '0;
    end else if (strb.push) begin
      wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
    end else if (strb.clear || strb.holdRd) begin
      rdPtr <= '0;
    end else if (strb.step) begin
      rdPtr <= strb.wrap ? '0 : rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) wrapQ <= 1'b0;
    else       wrapQ <= strb.wrap;
  end

  always_comb begin
    isFull     = (count == FULL_CNT);
    isEmpty    = (count == '0);
    atLast     = ((CNT_W'(rdPtr) + 1'b1) == count);
    curChan    = isEmpty ? '0 : entry[rdPtr];
    listWrap   = wrapQ;
    entryCount = count;
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  assert_rd_in_list_R6: assert property (@(posedge clk) disable iff (!rstN)
    !isEmpty |-> (CNT_W'(rdPtr) < count));

  assert_wrap_at_head_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrapQ |-> (rdPtr == '0));

  assert_cfg_holds_head_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.holdRd |=> (rdPtr == '0));

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (count == '0) && (wrPtr == '0));

endmodule

// File: rtl/chan_seq_list.sv
module chan_seq_list
  import chan_seq_pkg::*;
#(
  parameter int CHAN_W = 4,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgActive,
  input  logic              wrStb,
  input  logic [CHAN_W-1:0] wrChan,
  input  logic              clrStb,
  input  logic              nextReq,
  output logic [CHAN_W-1:0] curChan,
  output logic              listWrap,
  output logic [CNT_W-1:0]  entryCount,
  output logic              cfgErr
);

  seqStrb_t strb;
  logic     isFull;
  logic     isEmpty;
  logic     atLast;

  chan_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgActive (cfgActive),
    .wrStb     (wrStb),
    .clrStb    (clrStb),
    .nextReq   (nextReq),
    .isFull    (isFull),
    .isEmpty   (isEmpty),
    .atLast    (atLast),
    .strb      (strb),
    .cfgErr    (cfgErr)
  );

  chan_seq_dpath #(
    .CHAN_W (CHAN_W),
    .DEPTH  (DEPTH)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrChan     (wrChan),
    .curChan    (curChan),
    .listWrap   (listWrap),
    .entryCount (entryCount),
    .isFull     (isFull),
    .isEmpty    (isEmpty),
    .atLast     (atLast)
  );

  // Outside configuration the stored list never changes size.
  assert_frozen_outside_cfg_R3: assert property (@(posedge clk) disable iff (!rstN)
    !cfgActive |=> $stable(entryCount));

endmodule

// File: tb/tb_chan_seq_list.sv
`timescale 1ns/1ps
module tb_chan_seq_list;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cfgActive;
  logic       wrStb;
  logic [3:0] wrChan;
  logic       clrStb;
  logic       nextReq;
  logic [3:0] curChan;
  logic       listWrap;
  logic [4:0] entryCount;
  logic       cfgErr;

  int checks = 0;
  int failures = 0;
  int expList [16];

  always #4 clk = ~clk;

  chan_seq_list dut (
    .clk        (clk),
    .rstN       (rstN),
    .cfgActive  (cfgActive),
    .wrStb      (wrStb),
    .wrChan     (wrChan),
    .clrStb     (clrStb),
    .nextReq    (nextReq),
    .curChan    (curChan),
    .listWrap   (listWrap),
    .entryCount (entryCount),
    .cfgErr     (cfgErr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance one edge; inputs are changed and outputs sampled 1 ns after it.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    wrStb = 1'b0; clrStb = 1'b0; nextReq = 1'b0;
  endtask

  task automatic doClear();
    clrStb = 1'b1; tick(); clrStb = 1'b0;
  endtask

  task automatic doPush(input int ch);
    wrChan = 4'(ch); wrStb = 1'b1; tick(); wrStb = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; cfgActive = 1'b0; wrChan = '0;
    idle();
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    chk("R1 count", entryCount, 0);
    chk("R1 chan", curChan, 0);
    chk("R1 wrap", listWrap, 0);
    chk("R1 err", cfgErr, 0);

    // Empty list in generation
    nextReq = 1'b1; tick(); nextReq = 1'b0;
    chk("R8 empty chan", curChan, 0);
    chk("R8 empty wrap", listWrap, 0);

    // Sweep every list length
    for (int len = 1; len <= 16; len++) begin
      for (int i = 0; i < len; i++) expList[i] = (i * 7 + len) % 16;
      cfgActive = 1'b1;
      tick();
      doClear();
      chk("R9 cleared", entryCount, 0);
      chk("R4 err cleared", cfgErr, 0);
      for (int i = 0; i < len; i++) begin
        doPush(expList[i]);
        chk("R2 count", entryCount, i + 1);
        chk("R2 head", curChan, expList[0]);
      end
      nextReq = 1'b1; tick(); nextReq = 1'b0;
      chk("R7 hold chan", curChan, expList[0]);
      chk("R7 hold wrap", listWrap, 0);
      if (len == 16) begin
        doPush(9);
        chk("R5 full count", entryCount, 16);
        chk("R5 full err", cfgErr, 1);
        chk("R5 head intact", curChan, expList[0]);
      end
      cfgActive = 1'b0;
      tick();
      for (int s = 0; s <= 2 * len; s++) begin
        chk("R6 chan", curChan, expList[s % len]);
        nextReq = 1'b1; tick();
        chk("R6 wrap", listWrap, ((s % len) == len - 1) ? 1 : 0);
      end
      nextReq = 1'b0; tick();
      chk("R6 wrap one cycle", listWrap, 0);
    end

    // Full list (16) in generation, error still set from overflow
    chk("R4 err persists", cfgErr, 1);
    cfgActive = 1'b1; tick(); doClear(); cfgActive = 1'b0; tick();
    chk("R4 err cleared", cfgErr, 0);

    // Load 2 entries, then try changes outside configuration
    cfgActive = 1'b1; tick();
    doPush(5); doPush(11);
    cfgActive = 1'b0; tick();
    doPush(3);
    chk("R3 push count", entryCount, 2);
    chk("R3 push err", cfgErr, 1);
    chk("R3 push chan", curChan, 5);
    doClear();
    chk("R3 clear count", entryCount, 2);
    nextReq = 1'b1; tick(); nextReq = 1'b0;
    chk("R3 list intact", curChan, 11);
    nextReq = 1'b1; tick(); nextReq = 1'b0;
    chk("R3 list wraps", curChan, 5);

    // Accepted push does not lower the flag
    cfgActive = 1'b1; tick();
    doPush(7);
    chk("R4 push keeps err", cfgErr, 1);
    chk("R2 third entry count", entryCount, 3);

    // Clear and push in the same cycle
    wrChan = 4'd12; wrStb = 1'b1; clrStb = 1'b1; tick(); idle();
    chk("R9 clear wins count", entryCount, 0);
    chk("R9 no err", cfgErr, 0);
    chk("R9 empty chan", curChan, 0);
    doPush(12);
    chk("R9 push after clear", entryCount, 1);
    chk("R2 new head", curChan, 12);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule